// File: doc/BRIEF.md
# SPI Flash Program and Erase Sequencer

This block sits between a host that wants bytes written or a range erased in a serial NOR flash and a lower-level command engine that shifts single flash commands onto the wire. The host hands over one request: a program of some number of bytes at an offset, or an erase of a byte range. The sequencer turns it into the command stream the flash needs. Before every page or sector operation it waits for the device to go idle and sets the write-enable latch, retrying until the latch reads back as set. It also picks the address width of each operation from the target address.

A program is cut into pieces of at most one page, each streamed through from the host's byte port into the engine's data port. An erase begins at the offset rounded down to a sector boundary and steps one sector at a time until the range is covered. The sector size is given as a power of two and taken when the request is accepted. A zero-length request is refused with an error. A device that stays busy past a programmable number of status reads also ends the request with an error.

The controller is a state machine with these states. `S_IDLE` waits for a request. `S_POLL_RD` and `S_POLL_WT` issue and await a status read. `S_WREN_RD` and `S_WREN_WT` issue and await write-enable. `S_WEL_RD` and `S_WEL_WT` issue and await the status read that confirms the latch. `S_OP_RD` and `S_OP_WT` issue and await the page or sector command. `S_ADV` moves to the next piece. `S_DONE` and `S_FAIL` are one-cycle end states.

The transitions are as follows. From `S_IDLE` a request goes to `S_POLL_RD`, or to `S_FAIL` when its length is zero. Any `*_RD` state moves to its `*_WT` state when the engine accepts the command. `S_POLL_WT` goes to `S_WREN_RD` when the device is idle. If the device is busy it goes back to `S_POLL_RD`, or to `S_FAIL` once the limit is reached. `S_WREN_WT` goes to `S_WEL_RD`. `S_WEL_WT` goes to `S_OP_RD` when the latch is set, and back to `S_WREN_RD` when it is not. `S_OP_WT` goes to `S_ADV`. `S_ADV` goes to `S_DONE` after the last piece, and otherwise to `S_POLL_RD`. `S_DONE` and `S_FAIL` return to `S_IDLE`.

Top module: `flash_pe_seq`

## Requirements
- R1: Before each page or sector command the block issues status reads (opcode 0x05, command length 1, read direction, no address bytes), repeating them until bit 0 of the returned status (busy) is 0. No page or sector command is issued while the device reports busy.
- R2: Once the device is idle, the block issues write-enable (opcode 0x06, length 0, write direction, no address bytes) followed by a status read. It repeats this pair until bit 1 of the status (enable latch) is 1. A page or sector command follows only a status read that showed the latch set.
- R3: A program of L bytes at offset A becomes page-program commands at A, A+256, A+512, and so on. Each command has length min(256, remaining bytes) and write direction.
- R4: The host byte stream is forwarded to the engine data port in order, only while a page-program command is outstanding. Exactly as many bytes are forwarded as that command's length.
- R5: A command whose target address is below 0x1000000 uses 3 address bytes and opcode 0x02 (program) or 0xD8 (erase). A command at or above that address uses 4 address bytes and opcode 0x12 or 0xDC.
- R6: An erase of L bytes at offset A issues sector-erase commands from A rounded down to the sector size, stepping by the sector size while the address is below A+L. Each command has length 0 and write direction.
- R7: The sector size (2^req_sec_log2 bytes) and the poll limit are captured when the request is accepted. Later changes on those inputs do not affect the request in flight.
- R8: After reset, and between requests, req_ready is 1 and cmd_valid, req_done and req_err are 0. req_done is a single-cycle pulse after the last command of a request has completed, and req_ready is 1 again in the following cycle.
- R9: A request with length 0 issues no command and answers with a single-cycle req_err pulse instead of req_done.
- R10: The block counts busy status reads for each piece. If a read reports busy after the count has reached the captured limit, the request ends with req_err and no further command is issued. With limit N, N busy reads followed by an idle one still succeed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_erase | input | 1 | 1 = erase range, 0 = program bytes |
| req_addr | input | ADDR_W | Byte offset in the flash |
| req_len | input | LEN_W | Byte count of the request |
| req_sec_log2 | input | SEC_LOG_W | log2 of the sector size in bytes |
| req_poll_limit | input | CNT_W | Busy status reads allowed per piece |
| req_done | output | 1 | Pulse: request finished |
| req_err | output | 1 | Pulse: request refused or timed out |
| wdat_valid | input | 1 | Host program byte valid |
| wdat_ready | output | 1 | Host program byte taken |
| wdat_data | input | 8 | Host program byte |
| cmd_valid | output | 1 | Command offered to engine |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_opcode | output | 8 | Flash opcode |
| cmd_addr | output | ADDR_W | Command address |
| cmd_addr_bytes | output | 3 | Address bytes to send: 0, 3 or 4 |
| cmd_len | output | PG_W | Data bytes of the command |
| cmd_write | output | 1 | 1 = data goes to the flash |
| cmd_done | input | 1 | Pulse: engine finished the command |
| cmd_rdata | input | 8 | Status byte, valid with cmd_done of a status read |
| eng_wvalid | output | 1 | Program byte offered to engine |
| eng_wready | input | 1 | Engine takes the program byte |
| eng_wdata | output | 8 | Program byte to engine |

## Verification
The bench aims at the 3-byte/4-byte address border with a program that straddles 0x1000000 and an erase whose sectors fall on both sides of it. A wrong compare there sends the high half with a short opcode and a truncated address. It checks lengths of exactly 256 and 257, unaligned single-byte erases and zero-length requests, where an off-by-one shows as a missing or extra command, or as a hang instead of an error. The flash model holds busy for a chosen number of reads and ignores some write-enables. A sequencer that skips the latch confirmation or drops the timeout count issues a command to a busy or locked device, or times out one read early. The sector size and poll limit inputs are scrambled right after acceptance, which exposes any design that reads them live.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_POLL_RD,
        S_POLL_WT,
        S_WREN_RD,
        S_WREN_WT,
        S_WEL_RD,
        S_WEL_WT,
        S_OP_RD,
        S_OP_WT,
        S_ADV,
        S_DONE,
        S_FAIL
    } seq_state_t;

    localparam logic [7:0] OPC_STATUS  = 8'h05;
    localparam logic [7:0] OPC_WR_EN   = 8'h06;
    localparam logic [7:0] OPC_PROG_3B = 8'h02;
    localparam logic [7:0] OPC_PROG_4B = 8'h12;
    localparam logic [7:0] OPC_ERAS_3B = 8'hD8;
    localparam logic [7:0] OPC_ERAS_4B = 8'hDC;

    localparam int STS_BUSY_BIT = 0;
    localparam int STS_WEL_BIT  = 1;

endpackage

// File: rtl/flash_seq_opsel.sv
module flash_seq_opsel #(
    parameter int          ADDR_W     = 32,
    parameter longint      FOURB_BASE = 64'h0100_0000
) (
    input  logic              is_erase,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        opcode,
    output logic [2:0]        abytes
);
    import flash_seq_pkg::*;

    logic wide;

    always_comb begin
        wide = (addr >= ADDR_W'(FOURB_BASE));
        if (is_erase) begin
            opcode = wide ? OPC_ERAS_4B : OPC_ERAS_3B;
        end else begin
            opcode = wide ? OPC_PROG_4B : OPC_PROG_3B;
        end
        abytes = wide ? 3'd4 : 3'd3;
    end

endmodule

// File: rtl/flash_seq_walk.sv
module flash_seq_walk #(
    parameter  int ADDR_W     = 32,
    parameter  int LEN_W      = 24,
    parameter  int SEC_LOG_W  = 5,
    parameter  int PAGE_BYTES = 256,
    localparam int PG_W       = $clog2(PAGE_BYTES) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  logic                 is_erase_in,
    input  logic [ADDR_W-1:0]    addr_in,
    input  logic [LEN_W-1:0]     len_in,
    input  logic [SEC_LOG_W-1:0] sec_log2_in,
    output logic                 mode_erase,
    output logic [ADDR_W-1:0]    cur_addr,
    output logic [PG_W-1:0]      chunk_len,
    output logic                 last
);
    logic [ADDR_W:0]        end_addr;
    logic [LEN_W-1:0]       remain;
    logic [SEC_LOG_W-1:0]   sec_log2;
    logic [ADDR_W-1:0]      sec_bytes;
    logic [ADDR_W-1:0]      in_mask;
    logic [ADDR_W:0]        next_sec;

    assign sec_bytes = ADDR_W'(1) << sec_log2;
    assign in_mask   = ~((ADDR_W'(1) << sec_log2_in) - ADDR_W'(1));
    assign next_sec  = {1'b0, cur_addr} + {1'b0, sec_bytes};

    always_comb begin
        if (remain > LEN_W'(PAGE_BYTES)) begin
            chunk_len = PG_W'(PAGE_BYTES);
        end else begin
            chunk_len = PG_W'(remain);
        end
        if (mode_erase) begin
            last = (next_sec >= end_addr);
        end else begin
            last = (remain <= LEN_W'(PAGE_BYTES));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_erase <= 1'b0;
            cur_addr   <= '0;
            end_addr   <= '0;
            remain     <= '0;
            sec_log2   <= '0;
        end else if (load) begin
            mode_erase <= is_erase_in;
            sec_log2   <= sec_log2_in;
            cur_addr   <= is_erase_in ? (addr_in & in_mask) : addr_in;
            end_addr   <= {1'b0, addr_in} + (ADDR_W+1)'(len_in);
            remain     <= len_in;
        end else if (step) begin
            if (mode_erase) begin
                cur_addr <= cur_addr + sec_bytes;
            end else begin
                cur_addr <= cur_addr + ADDR_W'(chunk_len);
                remain   <= remain - LEN_W'(chunk_len);
            end
        end
    end

endmodule

// File: rtl/flash_seq_poll.sv
module flash_seq_poll #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clr,
    input  logic             bump,
    input  logic [CNT_W-1:0] limit_in,
    output logic             expired
);
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] busy_cnt;

    assign expired = (busy_cnt >= limit_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q  <= '0;
            busy_cnt <= '0;
        end else if (load) begin
            limit_q  <= limit_in;
            busy_cnt <= '0;
        end else if (clr) begin
            busy_cnt <= '0;
        end else if (bump && (busy_cnt != '1)) begin
            busy_cnt <= busy_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq #(
    parameter  int     ADDR_W     = 32,
    parameter  int     LEN_W      = 24,
    parameter  int     SEC_LOG_W  = 5,
    parameter  int     CNT_W      = 8,
    parameter  int     PAGE_BYTES = 256,
    parameter  longint FOURB_BASE = 64'h0100_0000,
    localparam int     PG_W       = $clog2(PAGE_BYTES) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_erase,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [SEC_LOG_W-1:0] req_sec_log2,
    input  logic [CNT_W-1:0]     req_poll_limit,
    output logic                 req_done,
    output logic                 req_err,
    input  logic                 wdat_valid,
    output logic                 wdat_ready,
    input  logic [7:0]           wdat_data,
    output logic                 cmd_valid,
    input  logic                 cmd_ready,
    output logic [7:0]           cmd_opcode,
    output logic [ADDR_W-1:0]    cmd_addr,
    output logic [2:0]           cmd_addr_bytes,
    output logic [PG_W-1:0]      cmd_len,
    output logic                 cmd_write,
    input  logic                 cmd_done,
    input  logic [7:0]           cmd_rdata,
    output logic                 eng_wvalid,
    input  logic                 eng_wready,
    output logic [7:0]           eng_wdata
);
    import flash_seq_pkg::*;

    seq_state_t state, state_nx;

    logic              accept;
    logic              zero_len;
    logic              sts_busy;
    logic              sts_wel;
    logic              unused_sts_bits;
    logic              mode_erase;
    logic [ADDR_W-1:0] cur_addr;
    logic [PG_W-1:0]   chunk_len;
    logic              last_piece;
    logic              poll_expired;
    logic              poll_bump;
    logic              step;
    logic [7:0]        op_opcode;
    logic [2:0]        op_abytes;
    logic              data_phase;

    assign accept          = (state == S_IDLE) && req_valid;
    assign zero_len        = (req_len == '0);
    assign sts_busy        = cmd_rdata[STS_BUSY_BIT];
    assign sts_wel         = cmd_rdata[STS_WEL_BIT];
    assign unused_sts_bits = ^cmd_rdata[7:2];
    assign step            = (state == S_ADV);
    assign poll_bump       = (state == S_POLL_WT) && cmd_done && sts_busy;

    flash_seq_walk #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .SEC_LOG_W  (SEC_LOG_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept && !zero_len),
        .step        (step),
        .is_erase_in (req_erase),
        .addr_in     (req_addr),
        .len_in      (req_len),
        .sec_log2_in (req_sec_log2),
        .mode_erase  (mode_erase),
        .cur_addr    (cur_addr),
        .chunk_len   (chunk_len),
        .last        (last_piece)
    );

    flash_seq_poll #(
        .CNT_W (CNT_W)
    ) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .clr      (step),
        .bump     (poll_bump),
        .limit_in (req_poll_limit),
        .expired  (poll_expired)
    );

    flash_seq_opsel #(
        .ADDR_W     (ADDR_W),
        .FOURB_BASE (FOURB_BASE)
    ) u_opsel (
        .is_erase (mode_erase),
        .addr     (cur_addr),
        .opcode   (op_opcode),
        .abytes   (op_abytes)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (req_valid) state_nx = zero_len ? S_FAIL : S_POLL_RD;
            S_POLL_RD: if (cmd_ready) state_nx = S_POLL_WT;
            S_POLL_WT: begin
                if (cmd_done) begin
                    if (!sts_busy)         state_nx = S_WREN_RD;
                    else if (poll_expired) state_nx = S_FAIL;
                    else                   state_nx = S_POLL_RD;
                end
            end
            S_WREN_RD: if (cmd_ready) state_nx = S_WREN_WT;
            S_WREN_WT: if (cmd_done)  state_nx = S_WEL_RD;
            S_WEL_RD:  if (cmd_ready) state_nx = S_WEL_WT;
            S_WEL_WT:  if (cmd_done)  state_nx = sts_wel ? S_OP_RD : S_WREN_RD;
            S_OP_RD:   if (cmd_ready) state_nx = S_OP_WT;
            S_OP_WT:   if (cmd_done)  state_nx = S_ADV;
            S_ADV:     state_nx = last_piece ? S_DONE : S_POLL_RD;
            S_DONE:    state_nx = S_IDLE;
            S_FAIL:    state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_valid      = 1'b0;
        cmd_opcode     = OPC_STATUS;
        cmd_addr       = '0;
        cmd_addr_bytes = 3'd0;
        cmd_len        = PG_W'(1);
        cmd_write      = 1'b0;
        data_phase     = 1'b0;
        unique case (state)
            S_POLL_RD, S_WEL_RD: begin
                cmd_valid = 1'b1;
            end
            S_WREN_RD: begin
                cmd_valid  = 1'b1;
                cmd_opcode = OPC_WR_EN;
                cmd_len    = '0;
                cmd_write  = 1'b1;
            end
            S_OP_RD: begin
                cmd_valid      = 1'b1;
                cmd_opcode     = op_opcode;
                cmd_addr       = cur_addr;
                cmd_addr_bytes = op_abytes;
                cmd_len        = mode_erase ? '0 : chunk_len;
                cmd_write      = 1'b1;
            end
            S_OP_WT: begin
                data_phase = !mode_erase;
            end
            default: begin
            end
        endcase
    end

    assign req_ready  = (state == S_IDLE);
    assign req_done   = (state == S_DONE);
    assign req_err    = (state == S_FAIL);
    assign eng_wvalid = wdat_valid && data_phase;
    assign wdat_ready = eng_wready && data_phase;
    assign eng_wdata  = wdat_data;

endmodule

// File: rtl/flash_pe_seq_chk.sv
module flash_pe_seq_chk #(
    parameter  int     ADDR_W     = 32,
    parameter  int     LEN_W      = 24,
    parameter  int     PAGE_BYTES = 256,
    parameter  longint FOURB_BASE = 64'h0100_0000,
    localparam int     PG_W       = $clog2(PAGE_BYTES) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LEN_W-1:0]  req_len,
    input logic              req_done,
    input logic              req_err,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [7:0]        cmd_opcode,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [2:0]        cmd_addr_bytes,
    input logic [PG_W-1:0]   cmd_len,
    input logic              cmd_write,
    input logic              cmd_done,
    input logic              cmd_wel,
    input logic              eng_wvalid
);
    logic       pend_status;
    logic       seen_wel;
    logic       is_prog;
    logic       is_eras;

    assign is_prog = (cmd_opcode == 8'h02) || (cmd_opcode == 8'h12);
    assign is_eras = (cmd_opcode == 8'hD8) || (cmd_opcode == 8'hDC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_status <= 1'b0;
            seen_wel    <= 1'b0;
        end else begin
            if (cmd_valid && cmd_ready) begin
                pend_status <= (cmd_opcode == 8'h05);
            end
            if (cmd_done && pend_status) begin
                seen_wel <= cmd_wel;
            end
        end
    end

    assert_cmd_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_opcode) && $stable(cmd_addr));

    assert_wel_before_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (is_prog || is_eras) |-> seen_wel);

    assert_page_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && is_prog |-> (cmd_len != '0) && (cmd_len <= PG_W'(PAGE_BYTES)) && cmd_write);

    assert_data_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_wvalid |-> !cmd_valid && !req_ready);

    assert_short_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_addr_bytes == 3'd3) |-> cmd_addr < ADDR_W'(FOURB_BASE));

    assert_long_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_addr_bytes == 3'd4) |-> cmd_addr >= ADDR_W'(FOURB_BASE));

    assert_erase_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && is_eras |-> (cmd_len == '0) && cmd_write);

    assert_done_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> req_ready && !req_done);

    assert_end_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_done && req_err));

    assert_zero_len_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_len == '0) |=> req_err);

endmodule

bind flash_pe_seq flash_pe_seq_chk #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .PAGE_BYTES (PAGE_BYTES),
    .FOURB_BASE (FOURB_BASE)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_len        (req_len),
    .req_done       (req_done),
    .req_err        (req_err),
    .cmd_valid      (cmd_valid),
    .cmd_ready      (cmd_ready),
    .cmd_opcode     (cmd_opcode),
    .cmd_addr       (cmd_addr),
    .cmd_addr_bytes (cmd_addr_bytes),
    .cmd_len        (cmd_len),
    .cmd_write      (cmd_write),
    .cmd_done       (cmd_done),
    .cmd_wel        (cmd_rdata[1]),
    .eng_wvalid     (eng_wvalid)
);

// File: tb/flash_pe_seq_bench.sv
`timescale 1ns/1ps
module flash_pe_seq_bench;

    localparam int          PAGE = 256;
    localparam int unsigned BASE = 32'h0100_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_erase = 1'b0;
    logic [31:0] req_addr = '0;
    logic [23:0] req_len = '0;
    logic [4:0]  req_sec_log2 = 5'd16;
    logic [7:0]  req_poll_limit = 8'd4;
    logic        req_done;
    logic        req_err;
    logic        wdat_valid;
    logic        wdat_ready;
    logic [7:0]  wdat_data;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [7:0]  cmd_opcode;
    logic [31:0] cmd_addr;
    logic [2:0]  cmd_addr_bytes;
    logic [8:0]  cmd_len;
    logic        cmd_write;
    logic        cmd_done;
    logic [7:0]  cmd_rdata;
    logic        eng_wvalid;
    logic        eng_wready;
    logic [7:0]  eng_wdata;

    always #2.5 clk = ~clk;

    flash_pe_seq u_flash_pe_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_erase(req_erase),
        .req_addr(req_addr), .req_len(req_len), .req_sec_log2(req_sec_log2),
        .req_poll_limit(req_poll_limit), .req_done(req_done), .req_err(req_err),
        .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_data(wdat_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
        .cmd_addr(cmd_addr), .cmd_addr_bytes(cmd_addr_bytes), .cmd_len(cmd_len),
        .cmd_write(cmd_write), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
        .eng_wvalid(eng_wvalid), .eng_wready(eng_wready), .eng_wdata(eng_wdata)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // expected command list
    int          exp_n;
    logic [7:0]  exp_opc  [64];
    int unsigned exp_addr [64];
    int          exp_len  [64];

    // flash / engine model state and log
    int          log_n;
    logic [7:0]  log_opc  [64];
    int unsigned log_addr [64];
    int          log_len  [64];
    int          log_ab   [64];
    int          phase, wait_ct, busy_left, cfg_busy, wren_left, cfg_wren;
    bit          wel, cur_pp, cur_er;
    int          pp_len, pp_cnt, idx, rd05;
    logic [7:0]  resp;
    bit          mism, stray, pp_bad, busy_bad, wel_bad, p05_bad, p06_bad;
    int          pat_base;

    function automatic logic [7:0] pat(input int k);
        return 8'(k * 7 + pat_base);
    endfunction

    task automatic build_exp(input bit er, input int unsigned a, input int l, input int lg);
        longint cur, fin, rem, c;
        exp_n = 0;
        if (er) begin
            cur = longint'(a) & ~((longint'(1) << lg) - 1);
            fin = longint'(a) + l;
            while (cur < fin) begin
                exp_opc[exp_n]  = (cur < BASE) ? 8'hD8 : 8'hDC;
                exp_addr[exp_n] = 32'(cur);
                exp_len[exp_n]  = 0;
                exp_n++;
                cur += longint'(1) << lg;
            end
        end else begin
            cur = a; rem = l;
            while (rem > 0) begin
                c = (rem > PAGE) ? PAGE : rem;
                exp_opc[exp_n]  = (cur < BASE) ? 8'h02 : 8'h12;
                exp_addr[exp_n] = 32'(cur);
                exp_len[exp_n]  = int'(c);
                exp_n++;
                cur += c; rem -= c;
            end
        end
    endtask

    // engine, flash and host byte source model (all driven at negedge)
    initial begin
        cmd_ready = 0; cmd_done = 0; cmd_rdata = 0; eng_wready = 0;
        wdat_valid = 0; wdat_data = 0; phase = 0; wait_ct = 0;
        forever begin
            @(negedge clk);
            cmd_done = 1'b0;
            if (eng_wvalid && eng_wready) begin
                if (phase != 1) stray = 1;
                if (eng_wdata !== pat(idx)) mism = 1;
                idx++; pp_cnt++;
            end
            if (eng_wvalid && cur_er) stray = 1;
            wdat_valid = ($urandom % 4) != 0;
            wdat_data  = pat(idx);
            case (phase)
                0: begin
                    eng_wready = 0;
                    cmd_ready  = ($urandom % 4) != 0;
                    if (cmd_ready && cmd_valid) begin
                        wait_ct = 1 + $urandom % 3;
                        phase   = 2;
                        resp    = 8'h00;
                        case (cmd_opcode)
                            8'h05: begin
                                rd05++;
                                if (cmd_len != 1 || cmd_write || cmd_addr_bytes != 0) p05_bad = 1;
                                resp = {6'b0, wel, busy_left != 0};
                                if (busy_left > 0) busy_left--;
                            end
                            8'h06: begin
                                if (cmd_len != 0 || !cmd_write || cmd_addr_bytes != 0) p06_bad = 1;
                                if (wren_left > 0) wren_left--; else wel = 1;
                            end
                            8'h02, 8'h12, 8'hD8, 8'hDC: begin
                                if (busy_left != 0) busy_bad = 1;
                                if (!wel) wel_bad = 1;
                                if (log_n < 64) begin
                                    log_opc[log_n]  = cmd_opcode;
                                    log_addr[log_n] = cmd_addr;
                                    log_len[log_n]  = int'(cmd_len);
                                    log_ab[log_n]   = int'(cmd_addr_bytes);
                                    log_n++;
                                end
                                wel = 0; busy_left = cfg_busy; wren_left = cfg_wren;
                                cur_er = (cmd_opcode == 8'hD8) || (cmd_opcode == 8'hDC);
                                cur_pp = !cur_er;
                                pp_len = int'(cmd_len); pp_cnt = 0;
                                if (cur_pp) phase = 1;
                            end
                            default: p05_bad = 1;
                        endcase
                    end
                end
                1: begin
                    cmd_ready = 0;
                    if (pp_cnt >= pp_len) begin
                        eng_wready = 0; phase = 2;
                    end else begin
                        eng_wready = ($urandom % 3) != 0;
                    end
                end
                default: begin
                    cmd_ready = 0; eng_wready = 0;
                    if (wait_ct == 0) begin
                        cmd_done  = 1'b1;
                        cmd_rdata = resp;
                        if (cur_pp && pp_cnt != pp_len) pp_bad = 1;
                        cur_pp = 0; cur_er = 0;
                        phase = 0;
                    end else begin
                        wait_ct--;
                    end
                end
            endcase
        end
    end

    task automatic run_req(input bit er, input int unsigned a, input int l, input int lg,
                           input int limit, input int busy, input int wren_ig,
                           input bit expect_err, input string tag);
        bit got_done, got_err;
        string rq;
        build_exp(er, a, l, lg);
        log_n = 0; rd05 = 0; idx = 0; pat_base = $urandom % 256;
        mism = 0; stray = 0; pp_bad = 0; busy_bad = 0; wel_bad = 0; p05_bad = 0; p06_bad = 0;
        cfg_busy = busy; busy_left = busy; cfg_wren = wren_ig; wren_left = wren_ig; wel = 0;
        @(negedge clk);
        req_valid = 1; req_erase = er; req_addr = a; req_len = 24'(l);
        req_sec_log2 = 5'(lg); req_poll_limit = 8'(limit);
        @(negedge clk);
        req_valid = 0;
        // R7: scramble latched inputs right after acceptance
        req_sec_log2 = 5'(lg) ^ 5'd4;
        req_poll_limit = 8'd0;
        got_done = 0; got_err = 0;
        for (int i = 0; i < 40000; i++) begin
            if (req_done) begin got_done = 1; break; end
            if (req_err)  begin got_err  = 1; break; end
            @(negedge clk);
        end
        @(negedge clk);
        check(!req_done && !req_err && req_ready, "R8", {tag, " single pulse/idle"},
              {req_done, req_err, req_ready}, 3'b001);
        if (expect_err) begin
            check(got_err && !got_done, "R9", {tag, " error end"}, {got_err, got_done}, 2'b10);
            check(log_n == 0, "R10", {tag, " no op after error"}, log_n, 0);
            return;
        end
        rq = er ? "R6" : "R3";
        check(got_done && !got_err, "R8", {tag, " done end"}, {got_done, got_err}, 2'b10);
        check(log_n == exp_n, er ? "R7" : "R3", {tag, " op count"}, log_n, exp_n);
        for (int k = 0; k < exp_n && k < log_n; k++) begin
            check(log_opc[k] == exp_opc[k], "R5", {tag, " opcode"}, log_opc[k], exp_opc[k]);
            check(log_ab[k] == ((exp_addr[k] < BASE) ? 3 : 4), "R5", {tag, " addr bytes"},
                  log_ab[k], (exp_addr[k] < BASE) ? 3 : 4);
            check(log_addr[k] == exp_addr[k], rq, {tag, " op addr"}, log_addr[k], exp_addr[k]);
            check(log_len[k] == exp_len[k], rq, {tag, " op len"}, log_len[k], exp_len[k]);
        end
        check(!busy_bad && !p05_bad, "R1", {tag, " poll discipline"}, {busy_bad, p05_bad}, 0);
        check(!wel_bad && !p06_bad, "R2", {tag, " write-enable discipline"}, {wel_bad, p06_bad}, 0);
        check(!mism && !stray && !pp_bad && idx == (er ? 0 : l), "R4", {tag, " data stream"},
              idx, er ? 0 : l);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got 0x1 expected 0x0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7351));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(req_ready && !cmd_valid && !req_done && !req_err, "R8", "reset state",
              {req_ready, cmd_valid, req_done, req_err}, 4'b1000);
        run_req(0, 32'h0000_1000, 256, 16, 4, 1, 0, 0, "R3 one full page");
        run_req(0, 32'h0000_2000, 257, 16, 4, 2, 1, 0, "R3 page plus one");
        run_req(0, 32'h00FF_FF80, 300, 16, 4, 0, 2, 0, "R5 program across border");
        run_req(1, 32'h0001_2345, 1, 16, 4, 1, 0, 0, "R6 one byte erase");
        run_req(1, 32'h00FF_8000, 32'h1_0000, 16, 4, 2, 1, 0, "R5 erase across border");
        run_req(1, 32'h0003_0000, 32'h2000, 12, 4, 0, 0, 0, "R7 small sector latched");
        run_req(0, 32'h0000_4000, 0, 16, 4, 0, 0, 1, "R9 zero program");
        run_req(1, 32'h0000_4000, 0, 16, 4, 0, 0, 1, "R9 zero erase");
        run_req(0, 32'h0000_5000, 10, 16, 3, 20, 0, 1, "R10 timeout");
        check(rd05 == 4, "R10", "busy reads before abort", rd05, 4);
        run_req(0, 32'h0000_6000, 10, 16, 3, 3, 0, 0, "R10 busy equal to limit");
        for (int t = 0; t < 14; t++) begin
            bit er;
            int lg, lim;
            int unsigned a;
            int l;
            er  = ($urandom % 2) == 1;
            lg  = (($urandom % 3) == 0) ? 12 : ((($urandom % 2) == 0) ? 16 : 18);
            lim = 2 + $urandom % 4;
            a   = $urandom % 32'h0200_0000;
            l   = er ? 1 + $urandom % (3 << lg) : 1 + $urandom % 700;
            run_req(er, a, l, lg, lim, $urandom % (lim + 1), $urandom % 3, 0,
                    er ? "R6 random erase" : "R3 random program");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule